// File: doc/BRIEF.md
# Working Register Bank with Data-Space Window and Auto-Updating Pointers

This block holds the thirty-two 8-bit working registers of a small 8-bit RISC core. Two combinational read ports supply the operands of a register-to-register or single-register operation. A clocked ALU write port stores the result at the same clock edge, so a whole operation completes in one cycle.

A second access path treats the registers as the lowest 32 addresses of the data space, so loads and stores can reach them like ordinary memory. The six highest registers pair up into three 16-bit address pointers. Each pointer can be used as it is, with a fixed displacement, with post-increment or with pre-decrement; the two update modes write the pair back in place.

A short-operand mode serves immediate-form instructions. In that mode the 4-bit register field is mapped onto the upper half of the file.

Top module: `gpr_bank`

## Requirements
- R1: `rd_a_data` and `rd_b_data` show, in the same cycle, the registers selected by the 5-bit `rd_a_sel` and `rd_b_sel`; any of R0 to R31 can be selected when `op_short` is 0.
- R2: With `alu_we` high, `alu_wdata` is written at the rising clock edge to the register selected by `alu_sel`. A read of that register in the same cycle returns the value it held before the edge.
- R3: When `op_short` is 1, the read index of port A and the ALU write index are both 16 plus `sel[3:0]`, and bit 4 of the select is ignored.
- R4: When `ds_addr` is below 0x20, `ds_hit` is 1, `ds_rdata` shows register number `ds_addr`, and `ds_we` writes `ds_wdata` to that register at the clock edge. At 0x20 or above, `ds_hit` and `ds_rdata` are 0 and a write changes no register.
- R5: `ptr_sel` picks a pointer: 0 selects R27:R26, 1 selects R29:R28, and 2 or 3 selects R31:R30, with the high byte in the odd register. `ptr_mode` 0 outputs the pointer value and mode 1 outputs the pointer plus the zero-extended 6-bit `ptr_disp`. Neither mode changes the pair.
- R6: In `ptr_mode` 2 (post-increment), `ptr_addr` is the current pointer value and the pair becomes pointer+1 at the edge. The carry crosses into the high byte and 0xFFFF wraps to 0x0000.
- R7: In `ptr_mode` 3 (pre-decrement), `ptr_addr` is pointer-1 and the pair becomes that value at the edge. The borrow crosses into the high byte and 0x0000 wraps to 0xFFFF.
- R8: When several writes reach one register in the same cycle, each byte takes the data-space write first, then the pointer update, then the ALU write.
- R9: Reset is synchronous and active low, and it clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_sel | input | 5 | Operand A register select |
| rd_b_sel | input | 5 | Operand B register select |
| op_short | input | 1 | Short-field mode for port A and ALU write |
| rd_a_data | output | 8 | Operand A value |
| rd_b_data | output | 8 | Operand B value |
| alu_we | input | 1 | ALU result write enable |
| alu_sel | input | 5 | ALU result destination |
| alu_wdata | input | 8 | ALU result value |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write value |
| ds_rdata | output | 8 | Data-space read value (0 on miss) |
| ds_hit | output | 1 | Address falls in the register window |
| ptr_sel | input | 2 | Pointer pair select |
| ptr_mode | input | 2 | 0 plain, 1 displacement, 2 post-increment, 3 pre-decrement |
| ptr_disp | input | 6 | Displacement for mode 1 |
| ptr_addr | output | 16 | Effective address from the pointer |

## Verification
Two situations can fall in the same cycle. In the first, the ALU write and a data-space store target one register. In the second, a pointer update targets a byte that a store or an ALU write also hits. The directed part of the bench sets up each collision on purpose and then reads the register back, expecting the winner the priority order names. A long randomized run then steers indices toward a small hot set that includes the pointer bytes, so these overlaps happen often. A behavioural model compares every output on every cycle, including reads of a register in the cycle it is written.

// File: rtl/gpr_pkg.sv
// Shared constants and types for the working register bank.
// Assumes an 8-bit core with 32 registers and three pointer pairs at the top.
package gpr_pkg;
    localparam int NUM_REGS   = 32;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int SHORT_BASE = NUM_REGS / 2;
    localparam int PTR_BASE   = NUM_REGS - 6;
    localparam int NUM_PTRS   = 3;

    typedef enum logic [1:0] {
        PM_PLAIN   = 2'd0,
        PM_DISP    = 2'd1,
        PM_POSTINC = 2'd2,
        PM_PREDEC  = 2'd3
    } ptr_mode_e;
endpackage

// File: rtl/gpr_index_decode.sv
// Turns raw register selects into file indices.
// In short mode the 4-bit field is offset into the upper half of the file.
// Assumes the select width equals IDX_W.
module gpr_index_decode
    import gpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_short,
    input  logic [IDX_W-1:0] sel_a,
    input  logic [IDX_W-1:0] sel_w,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_w
);
    localparam logic [IDX_W-1:0] BASE = IDX_W'(SHORT_BASE);

    // Map both selects through the short-field rule when requested.
    always_comb begin
        if (op_short) begin
            idx_a = BASE | {1'b0, sel_a[IDX_W-2:0]};
            idx_w = BASE | {1'b0, sel_w[IDX_W-2:0]};
        end else begin
            idx_a = sel_a;
            idx_w = sel_w;
        end
    end

    // R3: short mode can only reach the upper half
    assert_short_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_short |-> (idx_a[IDX_W-1] && idx_w[IDX_W-1]));
endmodule

// File: rtl/gpr_ptr_unit.sv
// Effective-address and next-value arithmetic for one selected pointer pair.
// Purely combinational; the caller supplies the pair bytes and applies the update.
module gpr_ptr_unit
    import gpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DISP_W = 6
) (
    input  logic [DATA_W-1:0]   pair_lo,
    input  logic [DATA_W-1:0]   pair_hi,
    input  ptr_mode_e           mode,
    input  logic [DISP_W-1:0]   disp,
    output logic [2*DATA_W-1:0] addr,
    output logic                upd_en,
    output logic [2*DATA_W-1:0] upd_val
);
    localparam int PW = 2 * DATA_W;

    logic [PW-1:0] cur;
    logic [PW-1:0] inc;
    logic [PW-1:0] dec;

    // Full-width add and subtract so carry and borrow cross the byte boundary.
    always_comb begin
        cur = {pair_hi, pair_lo};
        inc = cur + PW'(1);
        dec = cur - PW'(1);
    end

    // Pick the address and the write-back value by mode.
    always_comb begin
        upd_en  = 1'b0;
        upd_val = cur;
        case (mode)
            PM_PLAIN:   addr = cur;
            PM_DISP:    addr = cur + PW'(disp);
            PM_POSTINC: begin addr = cur; upd_en = 1'b1; upd_val = inc; end
            default:    begin addr = dec; upd_en = 1'b1; upd_val = dec; end
        endcase
    end
endmodule

// File: rtl/gpr_storage.sv
// Register array with a three-way write merge per byte.
// Priority per register: data-space write, then pointer update, then ALU write.
// Assumes indices are already decoded and the data-space enable is already gated by the hit.
module gpr_storage
    import gpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alu_we,
    input  logic [IDX_W-1:0]    alu_idx,
    input  logic [DATA_W-1:0]   alu_data,
    input  logic                ptr_we,
    input  logic [IDX_W-1:0]    ptr_lo_idx,
    input  logic [IDX_W-1:0]    ptr_hi_idx,
    input  logic [2*DATA_W-1:0] ptr_val,
    input  logic                ds_we,
    input  logic [IDX_W-1:0]    ds_idx,
    input  logic [DATA_W-1:0]   ds_data,
    output logic [DATA_W-1:0]   regs [NUM_REGS]
);
    logic [DATA_W-1:0] mem [NUM_REGS];
    logic [DATA_W-1:0] nxt [NUM_REGS];

    // Next value of every register under the fixed write priority.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ds_we && ds_idx == IDX_W'(i))
                nxt[i] = ds_data;
            else if (ptr_we && ptr_lo_idx == IDX_W'(i))
                nxt[i] = ptr_val[DATA_W-1:0];
            else if (ptr_we && ptr_hi_idx == IDX_W'(i))
                nxt[i] = ptr_val[2*DATA_W-1:DATA_W];
            else if (alu_we && alu_idx == IDX_W'(i))
                nxt[i] = alu_data;
            else
                nxt[i] = mem[i];
        end
    end

    // State update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= nxt[i];
        end
    end

    assign regs = mem;

    // R9: first cycle out of reset sees an all-zero file
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem[0] == '0 && mem[NUM_REGS-1] == '0 && mem[PTR_BASE] == '0));

    // R4: a data-space store always lands
    assert_ds_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ds_we |=> mem[$past(ds_idx)] == $past(ds_data));

    // R2: an uncontested ALU write lands
    assert_alu_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && !(ds_we && ds_idx == alu_idx)
                && !(ptr_we && (ptr_lo_idx == alu_idx || ptr_hi_idx == alu_idx)))
        |=> mem[$past(alu_idx)] == $past(alu_data));

    // R8: a pointer update beats the ALU but yields to a store
    assert_ptr_over_alu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && !(ds_we && ds_idx == ptr_lo_idx))
        |=> mem[$past(ptr_lo_idx)] == $past(ptr_val[DATA_W-1:0]));
endmodule

// File: rtl/gpr_bank.sv
// Working register bank: two operand reads, ALU write-back, data-space window
// at addresses 0x00-0x1F and three self-updating 16-bit pointer pairs.
// Assumes a single clock; all reads are combinational and show pre-edge state.
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4:0]          rd_a_sel,
    input  logic [4:0]          rd_b_sel,
    input  logic                op_short,
    output logic [DATA_W-1:0]   rd_a_data,
    output logic [DATA_W-1:0]   rd_b_data,
    input  logic                alu_we,
    input  logic [4:0]          alu_sel,
    input  logic [DATA_W-1:0]   alu_wdata,
    input  logic [ADDR_W-1:0]   ds_addr,
    input  logic                ds_we,
    input  logic [DATA_W-1:0]   ds_wdata,
    output logic [DATA_W-1:0]   ds_rdata,
    output logic                ds_hit,
    input  logic [1:0]          ptr_sel,
    input  logic [1:0]          ptr_mode,
    input  logic [DISP_W-1:0]   ptr_disp,
    output logic [2*DATA_W-1:0] ptr_addr
);
    localparam int PW = 2 * DATA_W;

    logic [IDX_W-1:0]  idx_a;
    logic [IDX_W-1:0]  idx_w;
    logic [IDX_W-1:0]  ds_idx;
    logic [IDX_W-1:0]  lo_idx;
    logic [IDX_W-1:0]  hi_idx;
    logic [1:0]        grp;
    logic              upd_en;
    logic [PW-1:0]     upd_val;
    logic              ds_wr;
    logic              ds_on_pair;
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [PW-1:0]     pair_val [NUM_PTRS];

    gpr_index_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_short (op_short),
        .sel_a    (rd_a_sel),
        .sel_w    (alu_sel),
        .idx_a    (idx_a),
        .idx_w    (idx_w)
    );

    // Window decode: only addresses below the file size hit.
    always_comb begin
        ds_hit = (ds_addr[ADDR_W-1:IDX_W] == '0);
        ds_idx = ds_addr[IDX_W-1:0];
        ds_wr  = ds_we && ds_hit;
    end

    // Pointer group: select 3 folds onto the last pair.
    always_comb begin
        grp    = (ptr_sel == 2'd3) ? 2'd2 : ptr_sel;
        lo_idx = IDX_W'(PTR_BASE) + {2'b00, grp, 1'b0};
        hi_idx = lo_idx | IDX_W'(1);
    end

    gpr_ptr_unit #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_ptr (
        .pair_lo (regs[lo_idx]),
        .pair_hi (regs[hi_idx]),
        .mode    (ptr_mode_e'(ptr_mode)),
        .disp    (ptr_disp),
        .addr    (ptr_addr),
        .upd_en  (upd_en),
        .upd_val (upd_val)
    );

    gpr_storage #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alu_we     (alu_we),
        .alu_idx    (idx_w),
        .alu_data   (alu_wdata),
        .ptr_we     (upd_en),
        .ptr_lo_idx (lo_idx),
        .ptr_hi_idx (hi_idx),
        .ptr_val    (upd_val),
        .ds_we      (ds_wr),
        .ds_idx     (ds_idx),
        .ds_data    (ds_wdata),
        .regs       (regs)
    );

    // Operand and window read muxes.
    always_comb begin
        rd_a_data = regs[idx_a];
        rd_b_data = regs[rd_b_sel];
        ds_rdata  = ds_hit ? regs[ds_idx] : '0;
    end

    // Pair views used by the pointer checks.
    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_pair
        assign pair_val[g] = {regs[PTR_BASE + 2*g + 1], regs[PTR_BASE + 2*g]};
    end

    // Whether a store touches either byte of the selected pair.
    always_comb ds_on_pair = ds_wr && (ds_idx == lo_idx || ds_idx == hi_idx);

    // R6: post-increment leaves the pair one past the address given out
    assert_postinc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_mode == 2'd2 && !ds_on_pair)
        |=> pair_val[$past(grp)] == $past(ptr_addr) + PW'(1));

    // R7: pre-decrement leaves the pair equal to the address given out
    assert_predec_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_mode == 2'd3 && !ds_on_pair)
        |=> pair_val[$past(grp)] == $past(ptr_addr));

    // R5: plain and displacement modes leave the pair alone without other writes
    assert_plain_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_mode < 2'd2 && !ds_on_pair && !(alu_we && (idx_w == lo_idx || idx_w == hi_idx)))
        |=> pair_val[$past(grp)] == $past(pair_val[grp]));
endmodule

// File: tb/tb_gpr_bank.sv
module tb_gpr_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_sel, rd_b_sel, alu_sel;
    logic        op_short, alu_we, ds_we;
    logic [7:0]  rd_a_data, rd_b_data, alu_wdata, ds_wdata, ds_rdata;
    logic [15:0] ds_addr, ptr_addr;
    logic        ds_hit;
    logic [1:0]  ptr_sel, ptr_mode;
    logic [5:0]  ptr_disp;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_bank dut (
        .clk(clk), .rst_n(rst_n), .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel),
        .op_short(op_short), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .alu_we(alu_we), .alu_sel(alu_sel), .alu_wdata(alu_wdata),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .ds_hit(ds_hit), .ptr_sel(ptr_sel),
        .ptr_mode(ptr_mode), .ptr_disp(ptr_disp), .ptr_addr(ptr_addr)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int idx_short(logic [4:0] s);
        return op_short ? 16 + int'(s[3:0]) : int'(s);
    endfunction

    function automatic int pair_lo();
        return 26 + 2 * ((ptr_sel == 2'd3) ? 2 : int'(ptr_sel));
    endfunction

    function automatic logic [15:0] pair_now();
        int lo = pair_lo();
        return {model[lo+1], model[lo]};
    endfunction

    // Compare every combinational output against the model.
    task automatic compare();
        logic [15:0] p = pair_now();
        logic [15:0] e;
        chk(op_short ? "R3 port A" : "R1 port A", {8'h0, rd_a_data}, {8'h0, model[idx_short(rd_a_sel)]});
        chk("R1 port B", {8'h0, rd_b_data}, {8'h0, model[rd_b_sel]});
        chk("R4 hit", {15'h0, ds_hit}, {15'h0, ds_addr < 16'h20});
        chk("R4 read", {8'h0, ds_rdata}, (ds_addr < 16'h20) ? {8'h0, model[ds_addr[4:0]]} : 16'h0);
        case (ptr_mode)
            2'd0: e = p;
            2'd1: e = p + {10'h0, ptr_disp};
            2'd2: e = p;
            default: e = p - 16'd1;
        endcase
        chk(ptr_mode == 2'd2 ? "R6 addr" : ptr_mode == 2'd3 ? "R7 addr" : "R5 addr", ptr_addr, e);
    endtask

    // Advance the model by one edge: ALU, then pointer, then store (later wins, R8).
    task automatic model_edge();
        logic [7:0] n [32];
        logic [15:0] p = pair_now();
        int lo = pair_lo();
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) model[i] = 8'h0;
            return;
        end
        n = model;
        if (alu_we) n[idx_short(alu_sel)] = alu_wdata;
        if (ptr_mode == 2'd2) begin p = p + 16'd1; n[lo] = p[7:0]; n[lo+1] = p[15:8]; end
        if (ptr_mode == 2'd3) begin p = p - 16'd1; n[lo] = p[7:0]; n[lo+1] = p[15:8]; end
        if (ds_we && ds_addr < 16'h20) n[ds_addr[4:0]] = ds_wdata;
        model = n;
    endtask

    task automatic cycle();
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        alu_we = 0; ds_we = 0; op_short = 0; ptr_mode = 2'd0; ptr_sel = 0;
        ptr_disp = 0; rd_a_sel = 0; rd_b_sel = 0; alu_sel = 0; ds_addr = 16'h40;
        alu_wdata = 0; ds_wdata = 0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [4:0] hot_idx();
        logic [4:0] hot [6] = '{5'd5, 5'd19, 5'd26, 5'd27, 5'd30, 5'd31};
        if ($urandom_range(1, 0) == 1) return hot[$urandom_range(5, 0)];
        return 5'($urandom_range(31, 0));
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 8'h0;
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R9: every register reads zero through the window after reset
        for (int r = 0; r < 32; r++) begin
            ds_addr = 16'(r);
            #1 chk("R9 reset", {8'h0, ds_rdata}, 16'h0);
        end
        idle();

        // R7: pre-decrement of X at 0x0000 wraps to 0xFFFF
        ptr_sel = 0; ptr_mode = 2'd3; cycle();
        idle(); ds_addr = 16'd26; #1 chk("R7 wrap low", {8'h0, ds_rdata}, 16'h00FF);
        ds_addr = 16'd27; #1 chk("R7 wrap high", {8'h0, ds_rdata}, 16'h00FF);

        // R6: post-increment of Y from 0x00FF carries into the high byte
        ds_we = 1; ds_addr = 16'd28; ds_wdata = 8'hFF; cycle();
        idle(); ptr_sel = 1; ptr_mode = 2'd2; cycle();
        idle(); ptr_sel = 1; #1 chk("R6 carry", ptr_addr, 16'h0100);
        cycle();

        // R8: store and ALU write to R5 in one cycle; the store wins
        idle(); alu_we = 1; alu_sel = 5; alu_wdata = 8'h11;
        ds_we = 1; ds_addr = 16'd5; ds_wdata = 8'h22; cycle();
        idle(); rd_a_sel = 5; #1 chk("R8 store wins", {8'h0, rd_a_data}, 16'h0022);
        cycle();

        // R8: pointer update beats an ALU write to Z low byte
        idle(); ptr_sel = 2; ptr_mode = 2'd2; alu_we = 1; alu_sel = 30; alu_wdata = 8'h77; cycle();
        idle(); rd_b_sel = 30; #1 chk("R8 pointer wins", {8'h0, rd_b_data}, 16'h0001);
        cycle();

        // R2: write and read R7 in the same cycle returns the old value
        idle(); alu_we = 1; alu_sel = 7; alu_wdata = 8'h33; rd_a_sel = 7;
        #1 chk("R2 old value", {8'h0, rd_a_data}, 16'h0000);
        cycle();
        idle(); rd_a_sel = 7; #1 chk("R2 new value", {8'h0, rd_a_data}, 16'h0033);

        // R3: short field 3 reaches R19 for read and write; bit 4 ignored
        idle(); op_short = 1; alu_we = 1; alu_sel = 5'd3; alu_wdata = 8'h5A; cycle();
        idle(); op_short = 1; rd_a_sel = 5'b00011; rd_b_sel = 19;
        #1 chk("R3 short read", {8'h0, rd_a_data}, 16'h005A);
        chk("R3 upper half", {8'h0, rd_b_data}, 16'h005A);
        cycle();

        // R4: a store above the window changes nothing
        idle(); ds_we = 1; ds_addr = 16'h0020; ds_wdata = 8'hEE; cycle();
        idle(); ds_addr = 16'h0020; #1 chk("R4 miss", {7'h0, ds_hit, ds_rdata}, 16'h0000);
        cycle();

        // R5: displacement mode on Z
        idle(); ptr_sel = 2; ptr_mode = 2'd1; ptr_disp = 6'd63; cycle();

        // Randomized run with biased collisions, checked every cycle
        for (int n = 0; n < 4000; n++) begin
            op_short  = ($urandom_range(3, 0) == 0);
            rd_a_sel  = hot_idx();
            rd_b_sel  = hot_idx();
            alu_we    = $urandom_range(1, 0) == 1;
            alu_sel   = hot_idx();
            alu_wdata = 8'($urandom);
            ds_we     = $urandom_range(2, 0) == 0;
            ds_addr   = ($urandom_range(4, 0) == 0) ? 16'($urandom) : {11'h0, hot_idx()};
            ds_wdata  = 8'($urandom);
            ptr_sel   = 2'($urandom);
            ptr_mode  = 2'($urandom);
            ptr_disp  = 6'($urandom);
            cycle();
        end
        report();
    end
endmodule